// File: doc/BRIEF.md
# Symbol Timing Phase Accumulator

This block is the phase generator of a symbol-timing recovery loop. On every master clock it adds a rate word to a 25-bit phase register that wraps modulo 2^25. The rate word is a nominal symbol-frequency word plus a signed correction from the timing loop filter. The output rate is (nominal + correction) × F_clk / 2^25. For example, a nominal word of 0x231A8B (2300555) gives about 1.64 MHz.

Two results come from each update. The first is a one-cycle strobe, raised when the addition runs past 2^25. It tells the downstream filter chain to keep one sample at symbol rate. The second is a 5-bit fractional index taken from the top of the phase, which selects the interpolator coefficient set. Both are registered at the same edge, so they always describe the same update. The loop filter, interpolator and error detector sit outside this block and only meet it at its ports.

Top module: `timing_nco`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase is cleared: after that edge `frac_idx` reads 0 and `sym_strobe` reads 0.
- R2: At each rising edge with `rst` low, the phase becomes (phase + rate) modulo 2^25, where rate = (`freq_word` + sign-extended `ted_err`) modulo 2^25.
- R3: `ted_err` is a 16-bit two's complement value, sign-extended to 25 bits before the addition. A negative total wraps: for example, `freq_word` = 10 with `ted_err` = -100 gives a rate of 2^25 - 90.
- R4: `sym_strobe` is high for the single cycle after an update whose unsigned 26-bit sum of phase and rate is 2^25 or more. It is low after every other update.
- R5: `frac_idx` equals bits 24 down to 20 of the phase, and it changes at the same edge as `sym_strobe`.
- R6: When the rate is 0 (for example, `freq_word` = 2^25 - 1 with `ted_err` = +1), the phase holds still and `sym_strobe` stays low.
- R7: Starting from a cleared phase, the number of strobes in N updates at a constant rate is floor(N × rate / 2^25). With `freq_word` = 0x231A8B and `ted_err` = 0, 1000 updates give 68 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 25 | Nominal symbol-frequency word |
| ted_err | input | 16 | Filtered timing error, signed two's complement |
| frac_idx | output | 5 | Fractional phase index for coefficient selection |
| sym_strobe | output | 1 | One-cycle symbol decimation strobe |

## Verification
The strobe and the fractional index move in the same cycle when the phase wraps. At that edge the index must fall from a high value to a low one just as the strobe rises. A wrong tap or a misaligned register would show up at exactly that point. The bench causes this in several ways: a steady nominal rate, a large rate that wraps on every other cycle, and a negative correction that turns the total into a large unsigned rate. On every clock it compares both outputs against a behavioural model built from integer arithmetic. A zero rate then checks that neither output changes and no strobe appears.

// File: rtl/timing_nco_pkg.sv
package timing_nco_pkg;
    localparam int NCO_ACC_W  = 25;
    localparam int NCO_ERR_W  = 16;
    localparam int NCO_FRAC_W = 5;
endpackage

// File: rtl/tnco_step_calc.sv
module tnco_step_calc #(
    parameter int ACC_W = timing_nco_pkg::NCO_ACC_W,
    parameter int ERR_W = timing_nco_pkg::NCO_ERR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        freq_word,
    input  logic signed [ERR_W-1:0] ted_err,
    output logic [ACC_W-1:0]        step
);
    localparam int EXT_W = ACC_W - ERR_W;

    logic [ACC_W-1:0] err_ext;

    always_comb begin
        err_ext = {{EXT_W{ted_err[ERR_W-1]}}, ted_err};
        step    = freq_word + err_ext;
    end

    // R3: a zero correction leaves the nominal word untouched
    a_r3_zero_err_passes_nominal: assert property (@(posedge clk) disable iff (rst)
        (ted_err == '0) |-> (step == freq_word));
endmodule

// File: rtl/tnco_phase_acc.sv
module tnco_phase_acc #(
    parameter int ACC_W = timing_nco_pkg::NCO_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase_q,
    output logic             wrap_q
);
    typedef struct packed {
        logic [ACC_W-1:0] phase;
        logic             wrap;
    } acc_t;

    acc_t         st_d, st_q;
    logic [ACC_W:0] sum_d;

    always_comb begin
        sum_d      = {1'b0, st_q.phase} + {1'b0, step};
        st_d.phase = sum_d[ACC_W-1:0];
        st_d.wrap  = sum_d[ACC_W];
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_q = st_q.phase;
    assign wrap_q  = st_q.wrap;

    // checker support: high when the previous edge was a real update
    logic upd_q;
    always_ff @(posedge clk) begin
        if (rst) upd_q <= 1'b0;
        else     upd_q <= 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) == 1'b1 |-> (phase_q == '0 && !wrap_q));

    a_r4_wrap_lands_low: assert property (@(posedge clk) disable iff (rst)
        (upd_q && wrap_q) |-> (phase_q < $past(step)));

    a_r4_no_wrap_no_fall: assert property (@(posedge clk) disable iff (rst)
        (upd_q && !wrap_q) |-> (phase_q >= $past(phase_q)));

    a_r6_zero_step_holds: assert property (@(posedge clk) disable iff (rst)
        (upd_q && $past(step) == '0) |-> (!wrap_q && $stable(phase_q)));
endmodule

// File: rtl/timing_nco.sv
module timing_nco #(
    parameter int ACC_W  = timing_nco_pkg::NCO_ACC_W,
    parameter int ERR_W  = timing_nco_pkg::NCO_ERR_W,
    parameter int FRAC_W = timing_nco_pkg::NCO_FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        freq_word,
    input  logic signed [ERR_W-1:0] ted_err,
    output logic [FRAC_W-1:0]       frac_idx,
    output logic                    sym_strobe
);
    localparam int FRAC_LSB = ACC_W - FRAC_W;

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase_q;
    logic             wrap_q;

    tnco_step_calc #(.ACC_W(ACC_W), .ERR_W(ERR_W)) u_step (
        .clk       (clk),
        .rst       (rst),
        .freq_word (freq_word),
        .ted_err   (ted_err),
        .step      (step)
    );

    tnco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .phase_q (phase_q),
        .wrap_q  (wrap_q)
    );

    // R5: index tap and strobe come from the same register
    assign frac_idx   = phase_q[FRAC_LSB +: FRAC_W];
    assign sym_strobe = wrap_q;

    a_r5_strobe_drops_index: assert property (@(posedge clk) disable iff (rst)
        (sym_strobe && $past(!rst) && $past(step) < (ACC_W'(1) << FRAC_LSB))
        |-> (frac_idx <= $past(frac_idx)));
endmodule

// File: tb/timing_nco_tb.sv
module timing_nco_tb;
    localparam longint MOD = 64'd1 << 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [24:0] freq_word = '0;
    logic signed [15:0] ted_err = '0;
    logic [4:0]  frac_idx;
    logic        sym_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_phase = 0;
    bit     m_strobe = 1'b0;
    int     strobe_count = 0;

    timing_nco u_dut (
        .clk        (clk),
        .rst        (rst),
        .freq_word  (freq_word),
        .ted_err    (ted_err),
        .frac_idx   (frac_idx),
        .sym_strobe (sym_strobe)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit r, input longint f, input int e);
        longint t;
        longint s;
        rst       = r;
        freq_word = f[24:0];
        ted_err   = e[15:0];
        @(posedge clk);
        if (r) begin
            m_phase  = 0;
            m_strobe = 1'b0;
        end else begin
            t = (f + longint'(e)) % MOD;
            if (t < 0) t += MOD;
            s = m_phase + t;
            m_strobe = (s >= MOD);
            m_phase  = s % MOD;
        end
        @(negedge clk);
        check({tag, " frac"}, frac_idx, m_phase >> 20);
        check({tag, " strobe"}, sym_strobe, m_strobe);
        if (sym_strobe) strobe_count++;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        step("R1", 1'b1, 0, 0);
        step("R1", 1'b1, 25'h123456, 77);

        // R7: nominal rate, strobe count over 1000 updates
        strobe_count = 0;
        for (int i = 0; i < 1000; i++) step("R2 R4 R5", 1'b0, 25'h231A8B, 0);
        check("R7 strobe count", strobe_count, 68);

        // R3: positive and negative corrections
        for (int i = 0; i < 200; i++) step("R3 pos", 1'b0, 25'h231A8B, 3000);
        for (int i = 0; i < 200; i++) step("R3 neg", 1'b0, 25'h231A8B, -3000);

        // R3: negative total wraps into a large rate, strobe nearly every cycle
        strobe_count = 0;
        for (int i = 0; i < 20; i++) step("R3 R4 wrap", 1'b0, 10, -100);
        check("R3 large-rate strobes", (strobe_count >= 19) ? 1 : 0, 1);

        // R4 R5: half-range rate, wrap on alternate updates
        for (int i = 0; i < 16; i++) step("R4 R5 half", 1'b0, MOD / 2, 0);

        // R6: zero rate holds phase, no strobe
        strobe_count = 0;
        for (int i = 0; i < 30; i++) step("R6 hold", 1'b0, MOD - 1, 1);
        check("R6 no strobe", strobe_count, 0);

        // R1: reset in mid-run, then restart
        for (int i = 0; i < 5; i++) step("R2", 1'b0, 25'h1FFFFFF, -7);
        step("R1 midrun", 1'b1, 25'h1FFFFFF, -7);
        for (int i = 0; i < 40; i++) step("R2 R4 restart", 1'b0, 25'h0F00000, 300);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule